// File: doc/BRIEF.md
# In-Order Descriptor Retire Tracker

This block follows the progress of a circular descriptor ring shared between a submit side and a transmit engine. The engine publishes the index of the next descriptor it will fetch (the hardware head). The tracker keeps its own software head and steps it forward by one descriptor per clock until it catches up. Each step adds one to a removed-descriptor count. Each submitted request is queued as a start index, an end index and a tag. A request is reported complete, in submission order, in the cycle the software head lands on its end index. Descriptors that belong to no request are stepped over silently.

The submit side also advances a tail index and a two-bit generation, which counts tail wraps, by the number of descriptors it adds. It reads back a free-slot count. A flush aborts every queued request, one per cycle and in order. It also brings the removed count up to the added count and zeroes the head, tail and generation. A request submitted while the engine is stopped is never placed on the ring: it is queued with zero indices and aborted at once.

Top module: `dma_retire_tracker`

## Requirements
- R1: After a synchronous active-low reset: sw_head, tail_idx, gen, added_cnt and removed_cnt are 0, free_slots is RING_DEPTH-1, and cpl_valid, progress and req_full are 0.
- R2: While sw_head differs from hw_head and neither a flush nor an abort drain is in progress, sw_head advances by exactly one per clock, going from RING_DEPTH-1 to 0. progress is 1 in the cycle after each clock that retired a descriptor, and 0 otherwise.
- R3: removed_cnt rises by one for every retired descriptor and never decreases (modulo 2^CNT_W). On a flush it moves up by at most RING_DEPTH-1.
- R4: A queued request completes with cpl_valid=1 and cpl_aborted=0 (0 = OK, 1 = aborted) in the cycle sw_head becomes equal to its end index. The completion carries the request's tag, start and end. The next queued request then becomes current.
- R5: Retiring a descriptor that does not bring sw_head onto the current request's end index produces no completion.
- R6: A submit accepted while eng_running=1 adds sub_ndesc to added_cnt. It moves tail_idx forward by sub_ndesc modulo RING_DEPTH, and increments gen when the tail passes RING_DEPTH-1. free_slots always equals RING_DEPTH-1-(added_cnt-removed_cnt).
- R7: On a flush clock, removed_cnt becomes added_cnt and sw_head, tail_idx and gen become 0. No descriptor retires and any submit in that clock is ignored. From the next clock on, every queued request completes with cpl_aborted=1, one per clock, in submission order.
- R8: A submit accepted while eng_running=0 leaves added_cnt, tail_idx and gen unchanged. It is queued with start=end=0 and is then completed with cpl_aborted=1 after any requests queued before it.
- R9: req_full is 1 when REQ_SLOTS requests are queued. A submit in a clock where the queue is full and nothing completes is ignored: no counter moves and no completion for it ever appears. A submit in a clock where a completion frees a slot is accepted.
- R10: While an abort drain is in progress, sw_head does not move even if hw_head differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_running | input | 1 | Transmit engine is running |
| sub_valid | input | 1 | Submit a request this clock |
| sub_start | input | IDX_W | First descriptor index of the request |
| sub_end | input | IDX_W | Index one past the request's last descriptor |
| sub_tag | input | TAG_W | Request tag returned on completion |
| sub_ndesc | input | IDX_W | Descriptors added to the ring by this submit |
| hw_head | input | IDX_W | Head index reported by the engine |
| flush | input | 1 | Abort all queued requests and resynchronise |
| sw_head | output | IDX_W | Software head index |
| tail_idx | output | IDX_W | Ring tail index |
| gen | output | GEN_W | Tail wrap generation |
| added_cnt | output | CNT_W | Total descriptors added |
| removed_cnt | output | CNT_W | Total descriptors retired, monotonic |
| free_slots | output | IDX_W+1 | Free ring entries for the submit side |
| req_full | output | 1 | Request queue full |
| progress | output | 1 | A descriptor retired on the last clock |
| cpl_valid | output | 1 | Completion strobe |
| cpl_aborted | output | 1 | Completion status, 1 = aborted |
| cpl_tag | output | TAG_W | Tag of the completed request |
| cpl_start | output | IDX_W | Start index of the completed request |
| cpl_end | output | IDX_W | End index of the completed request |

## Verification
The queue can be pushed by a submit and popped by an in-order completion in the same clock. The bench fills the queue to REQ_SLOTS entries and times a new submit so that it meets the head landing on the oldest request's end index. It expects the submit to be accepted (added_cnt grows, req_full stays high) and the new tag to complete last. A second collision puts a flush and a submit into a clock where a retire is also pending. The bench expects no step, no OK completion, counters resynchronised, and only the older requests aborted, while the head stays frozen through the drain.

// File: rtl/rtr_pkg.sv
// Package: shared definitions for the descriptor retire tracker.
// Assumes ring indices fit in a plain unsigned vector of the width the user derives.
package rtr_pkg;

    // Completion status as driven on cpl_aborted.
    typedef enum logic {
        CPL_OK    = 1'b0,
        CPL_ABORT = 1'b1
    } cpl_status_e;

endpackage

// File: rtl/rtr_req_queue.sv
// Module: rtr_req_queue
// Small first-in first-out store of outstanding requests. The front entry is
// always visible. Assumes the caller never pops when empty and never pushes
// when full unless it pops in the same clock.
module rtr_req_queue #(
    parameter int ENT_W = 12,
    parameter int SLOTS = 4,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int QCNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ENT_W-1:0]  data_i,
    output logic [ENT_W-1:0]  front_o,
    output logic [QCNT_W-1:0] count_o,
    output logic              full_o,
    output logic              empty_o
);

    logic [ENT_W-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [QCNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign front_o = slot_q[rd_q];
    assign count_o = cnt_q;
    assign full_o  = (cnt_q == QCNT_W'(SLOTS));
    assign empty_o = (cnt_q == '0);

    // Store a pushed entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push_i) begin
            slot_q[wr_q] <= data_i;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= ptr_inc(wr_q);
            if (pop_i)  rd_q <= ptr_inc(rd_q);
            case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!full_o || pop_i)); // R9
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R4

endmodule

// File: rtl/rtr_head_walker.sv
// Module: rtr_head_walker
// Owns the software head and the removed-descriptor count. One descriptor
// retires per enabled clock, wrapping at the ring depth. A clear zeroes the
// head and loads the removed count from the resync value; the caller keeps
// step_i low in a clear clock.
module rtr_head_walker #(
    parameter int RING_DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] resync_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] head_next_o,
    output logic [CNT_W-1:0] removed_o,
    output logic             progress_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] removed_q;
    logic             prog_q;

    // Index the head would take after one retire.
    always_comb begin
        head_next_o = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
    end

    // Advance or clear the head and removed count; flag progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q    <= '0;
            removed_q <= '0;
            prog_q    <= 1'b0;
        end else if (clr_i) begin
            head_q    <= '0;
            removed_q <= resync_i;
            prog_q    <= 1'b0;
        end else begin
            prog_q <= step_i;
            if (step_i) begin
                head_q    <= head_next_o;
                removed_q <= removed_q + 1'b1;
            end
        end
    end

    assign head_o     = head_q;
    assign removed_o  = removed_q;
    assign progress_o = prog_q;

    AST_HEAD_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i) |=> head_q == (($past(head_q) == LAST_IDX) ? '0 : IDX_W'($past(head_q) + 1'b1))); // R2
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(head_q)); // R2

endmodule

// File: rtl/rtr_ring_acct.sv
// Module: rtr_ring_acct
// Submit-side bookkeeping: tail index, wrap generation, added count and the
// free-slot figure. Assumes a submit never adds more descriptors than free.
module rtr_ring_acct #(
    parameter int RING_DEPTH = 16,
    parameter int CNT_W = 16,
    parameter int GEN_W = 2,
    localparam int IDX_W = $clog2(RING_DEPTH),
    localparam int FREE_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [IDX_W-1:0]  ndesc_i,
    input  logic [CNT_W-1:0]  removed_i,
    output logic [IDX_W-1:0]  tail_o,
    output logic [GEN_W-1:0]  gen_o,
    output logic [CNT_W-1:0]  added_o,
    output logic [FREE_W-1:0] free_o
);

    logic [IDX_W-1:0] tail_q;
    logic [GEN_W-1:0] gen_q;
    logic [CNT_W-1:0] added_q;
    logic [IDX_W:0]   tail_sum;
    logic             tail_wraps;
    logic [CNT_W-1:0] inflight;

    // Raw tail sum and wrap detection.
    always_comb begin
        tail_sum   = {1'b0, tail_q} + {1'b0, ndesc_i};
        tail_wraps = (tail_sum >= (IDX_W + 1)'(RING_DEPTH));
    end

    // Update the tail, generation and added count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q  <= '0;
            gen_q   <= '0;
            added_q <= '0;
        end else if (clr_i) begin
            tail_q <= '0;
            gen_q  <= '0;
        end else if (adv_i) begin
            tail_q  <= tail_wraps ? IDX_W'(tail_sum - (IDX_W + 1)'(RING_DEPTH)) : IDX_W'(tail_sum);
            gen_q   <= gen_q + GEN_W'(tail_wraps);
            added_q <= added_q + CNT_W'(ndesc_i);
        end
    end

    // Free entries: one slot is kept empty to tell full from empty.
    always_comb begin
        inflight = added_q - removed_i;
        free_o   = FREE_W'(CNT_W'(RING_DEPTH - 1) - inflight);
    end

    assign tail_o  = tail_q;
    assign gen_o   = gen_q;
    assign added_o = added_q;

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(RING_DEPTH - 1)); // R6

endmodule

// File: rtl/dma_retire_tracker.sv
// Module: dma_retire_tracker
// Retires ring descriptors one per clock toward the engine's head index and
// reports in-order completion of queued requests. A flush, or a submit while
// the engine is stopped, starts an abort drain that empties the queue one
// entry per clock. Assumes sub_end equals the tail after the submit and that
// hw_head never runs past the tail.
module dma_retire_tracker #(
    parameter int RING_DEPTH = 16,
    parameter int TAG_W = 4,
    parameter int REQ_SLOTS = 4,
    parameter int CNT_W = 16,
    parameter int GEN_W = 2,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_running,
    input  logic             sub_valid,
    input  logic [IDX_W-1:0] sub_start,
    input  logic [IDX_W-1:0] sub_end,
    input  logic [TAG_W-1:0] sub_tag,
    input  logic [IDX_W-1:0] sub_ndesc,
    input  logic [IDX_W-1:0] hw_head,
    input  logic             flush,
    output logic [IDX_W-1:0] sw_head,
    output logic [IDX_W-1:0] tail_idx,
    output logic [GEN_W-1:0] gen,
    output logic [CNT_W-1:0] added_cnt,
    output logic [CNT_W-1:0] removed_cnt,
    output logic [IDX_W:0]   free_slots,
    output logic             req_full,
    output logic             progress,
    output logic             cpl_valid,
    output logic             cpl_aborted,
    output logic [TAG_W-1:0] cpl_tag,
    output logic [IDX_W-1:0] cpl_start,
    output logic [IDX_W-1:0] cpl_end
);

    import rtr_pkg::*;

    localparam int ENT_W  = 2 * IDX_W + TAG_W;
    localparam int QCNT_W = $clog2(REQ_SLOTS + 1);

    logic [ENT_W-1:0]  push_ent, front_ent;
    logic [QCNT_W-1:0] q_count;
    logic              q_full, q_empty;
    logic              accept, push, pop, drain_pop, retire_pop, step;
    logic              drain_q;
    logic [IDX_W-1:0]  head_now, head_next, front_end;
    logic [CNT_W-1:0]  added_now, removed_now;

    logic              cpl_v_q;
    cpl_status_e       cpl_st_q;
    logic [ENT_W-1:0]  cpl_ent_q;

    assign front_end = front_ent[TAG_W +: IDX_W];

    // Admission, retire and pop decisions for this clock.
    always_comb begin
        accept     = sub_valid && !flush && (!q_full || retire_pop || drain_pop);
        push       = accept;
        push_ent   = eng_running ? {sub_start, sub_end, sub_tag} : {{(2 * IDX_W){1'b0}}, sub_tag};
        step       = !flush && !drain_q && (head_now != hw_head);
        retire_pop = step && !q_empty && (front_end == head_next);
        drain_pop  = drain_q && !flush && !q_empty;
        pop        = retire_pop || drain_pop;
    end

    rtr_req_queue #(.ENT_W(ENT_W), .SLOTS(REQ_SLOTS)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .data_i  (push_ent),
        .front_o (front_ent),
        .count_o (q_count),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    rtr_head_walker #(.RING_DEPTH(RING_DEPTH), .CNT_W(CNT_W)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (flush),
        .resync_i    (added_now),
        .step_i      (step),
        .head_o      (head_now),
        .head_next_o (head_next),
        .removed_o   (removed_now),
        .progress_o  (progress)
    );

    rtr_ring_acct #(.RING_DEPTH(RING_DEPTH), .CNT_W(CNT_W), .GEN_W(GEN_W)) u_acct (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (flush),
        .adv_i     (accept && eng_running),
        .ndesc_i   (sub_ndesc),
        .removed_i (removed_now),
        .tail_o    (tail_idx),
        .gen_o     (gen),
        .added_o   (added_now),
        .free_o    (free_slots)
    );

    // Abort-drain mode: entered by flush or a stopped-engine submit, left once empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= 1'b0;
        end else if (flush || (accept && !eng_running)) begin
            drain_q <= 1'b1;
        end else if (drain_q && (q_count == '0) && !push) begin
            drain_q <= 1'b0;
        end
    end

    // Register the completion strobe with the popped entry and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_v_q   <= 1'b0;
            cpl_st_q  <= CPL_OK;
            cpl_ent_q <= '0;
        end else begin
            cpl_v_q <= pop;
            if (pop) begin
                cpl_st_q  <= drain_pop ? CPL_ABORT : CPL_OK;
                cpl_ent_q <= front_ent;
            end
        end
    end

    assign sw_head     = head_now;
    assign added_cnt   = added_now;
    assign removed_cnt = removed_now;
    assign req_full    = q_full;
    assign cpl_valid   = cpl_v_q;
    assign cpl_aborted = (cpl_st_q == CPL_ABORT);
    assign cpl_tag     = cpl_ent_q[0 +: TAG_W];
    assign cpl_end     = cpl_ent_q[TAG_W +: IDX_W];
    assign cpl_start   = cpl_ent_q[TAG_W + IDX_W +: IDX_W];

    AST_OK_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_aborted) |-> progress); // R4
    AST_REMOVED_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(removed_cnt - $past(removed_cnt)) <= CNT_W'(RING_DEPTH - 1)); // R3
    AST_FLUSH_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (removed_cnt == added_cnt && sw_head == '0 && tail_idx == '0)); // R7
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_q && !flush) |=> $stable(sw_head)); // R10

endmodule

// File: tb/tb_dma_retire_tracker.sv
module tb_dma_retire_tracker;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n, eng_running, sub_valid, flush;
    logic [3:0] sub_start, sub_end, sub_tag, sub_ndesc, hw_head;
    logic [3:0] sw_head, tail_idx, cpl_tag, cpl_start, cpl_end;
    logic [1:0] gen;
    logic [15:0] added_cnt, removed_cnt;
    logic [4:0] free_slots;
    logic       req_full, progress, cpl_valid, cpl_aborted;

    int n_checks = 0;
    int n_fail = 0;
    int m_tail = 0, m_gen = 0, m_added = 0, m_removed = 0, m_head = 0;

    // Vectors: {ndesc, leading skipped descriptors, tag}
    localparam logic [11:0] VEC [6] = '{12'h301, 12'h522, 12'h413, 12'h604, 12'h215, 12'h736};

    always #5 clk = ~clk;

    dma_retire_tracker dut (
        .clk(clk), .rst_n(rst_n), .eng_running(eng_running), .sub_valid(sub_valid),
        .sub_start(sub_start), .sub_end(sub_end), .sub_tag(sub_tag), .sub_ndesc(sub_ndesc),
        .hw_head(hw_head), .flush(flush), .sw_head(sw_head), .tail_idx(tail_idx), .gen(gen),
        .added_cnt(added_cnt), .removed_cnt(removed_cnt), .free_slots(free_slots),
        .req_full(req_full), .progress(progress), .cpl_valid(cpl_valid),
        .cpl_aborted(cpl_aborted), .cpl_tag(cpl_tag), .cpl_start(cpl_start), .cpl_end(cpl_end)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic drive_sub(input int start, input int end_i, input int tag, input int nd);
        sub_valid = 1'b1;
        sub_start = 4'(start);
        sub_end   = 4'(end_i);
        sub_tag   = 4'(tag);
        sub_ndesc = 4'(nd);
    endtask

    task automatic model_add(input int nd);
        m_added += nd;
        if (m_tail + nd >= DEPTH) m_gen++;
        m_tail = (m_tail + nd) % DEPTH;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL WDOG run did not finish actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int exp_tags[5];
        rst_n = 1'b0; eng_running = 1'b1; sub_valid = 1'b0; flush = 1'b0;
        sub_start = '0; sub_end = '0; sub_tag = '0; sub_ndesc = '0; hw_head = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk("R1", "sw_head", sw_head, 0);
        chk("R1", "tail", tail_idx, 0);
        chk("R1", "gen", gen, 0);
        chk("R1", "added", added_cnt, 0);
        chk("R1", "removed", removed_cnt, 0);
        chk("R1", "free", free_slots, DEPTH - 1);
        chk("R1", "cpl_valid", cpl_valid, 0);
        chk("R1", "progress", progress, 0);
        chk("R1", "req_full", req_full, 0);

        // Vector table: submit, then retire to the new tail
        foreach (VEC[i]) begin
            int nd, skip, tag, old_tail, endi;
            nd = int'(VEC[i][11:8]); skip = int'(VEC[i][7:4]); tag = int'(VEC[i][3:0]);
            old_tail = m_tail;
            endi = (m_tail + nd) % DEPTH;
            drive_sub((m_tail + skip) % DEPTH, endi, tag, nd);
            cyc();
            sub_valid = 1'b0;
            model_add(nd);
            chk("R6", "tail", tail_idx, m_tail);
            chk("R6", "gen", gen, m_gen);
            chk("R6", "added", added_cnt, m_added);
            chk("R6", "free", free_slots, DEPTH - 1 - (m_added - m_removed));
            hw_head = 4'(endi);
            for (int k = 1; k <= nd; k++) begin
                cyc();
                m_removed++;
                chk("R2", "sw_head step", sw_head, (old_tail + k) % DEPTH);
                chk("R2", "progress", progress, 1);
                chk("R3", "removed", removed_cnt, m_removed);
                if (k < nd) begin
                    chk("R5", "no completion mid-request", cpl_valid, 0);
                end else begin
                    chk("R4", "cpl_valid", cpl_valid, 1);
                    chk("R4", "cpl_tag", cpl_tag, tag);
                    chk("R4", "cpl_aborted", cpl_aborted, 0);
                    chk("R4", "cpl_start", cpl_start, (old_tail + skip) % DEPTH);
                    chk("R4", "cpl_end", cpl_end, endi);
                end
            end
            cyc();
            chk("R2", "progress idle", progress, 0);
            chk("R2", "head holds", sw_head, endi);
        end
        m_head = m_tail;

        // Fill the queue: four requests of two descriptors each
        for (int t = 0; t < 4; t++) begin
            drive_sub(m_tail, (m_tail + 2) % DEPTH, 10 + t, 2);
            cyc();
            model_add(2);
        end
        sub_valid = 1'b0;
        chk("R9", "req_full", req_full, 1);
        chk("R6", "free", free_slots, DEPTH - 1 - (m_added - m_removed));
        // Submit while full with no completion: ignored (tag 14)
        drive_sub(m_tail, (m_tail + 2) % DEPTH, 14, 2);
        cyc();
        sub_valid = 1'b0;
        chk("R9", "added after rejected submit", added_cnt, m_added);
        chk("R9", "tail after rejected submit", tail_idx, m_tail);
        hw_head = 4'(m_tail);
        exp_tags = '{10, 11, 12, 13, 15};
        for (int k = 1; k <= 10; k++) begin
            if (k == 2) drive_sub(m_tail, (m_tail + 2) % DEPTH, 15, 2);
            cyc();
            m_removed++;
            if (k == 2) begin
                sub_valid = 1'b0;
                model_add(2);
                chk("R9", "submit accepted on pop", added_cnt, m_added);
                chk("R9", "still full after swap", req_full, 1);
                hw_head = 4'(m_tail);
            end
            chk("R2", "head walk", sw_head, (m_head + k) % DEPTH);
            if (k % 2 == 0) begin
                chk("R4", "in-order cpl_valid", cpl_valid, 1);
                chk("R4", "in-order tag", cpl_tag, exp_tags[k / 2 - 1]);
                chk("R4", "status ok", cpl_aborted, 0);
            end else begin
                chk("R5", "no cpl odd step", cpl_valid, 0);
            end
        end
        repeat (3) begin
            cyc();
            chk("R9", "rejected tag never completes", cpl_valid, 0);
        end
        chk("R3", "removed after walk", removed_cnt, m_removed);
        m_head = m_tail;

        // Flush with a retire pending and a submit in the same clock
        drive_sub(m_tail, (m_tail + 3) % DEPTH, 1, 3); cyc(); model_add(3);
        drive_sub(m_tail, (m_tail + 4) % DEPTH, 2, 4); cyc(); model_add(4);
        sub_valid = 1'b0;
        hw_head = 4'(m_tail);
        cyc(); cyc();
        m_removed += 2;
        chk("R3", "removed before flush", removed_cnt, m_removed);
        flush = 1'b1;
        drive_sub(m_tail, (m_tail + 2) % DEPTH, 7, 2);
        cyc();
        flush = 1'b0; sub_valid = 1'b0;
        chk("R7", "head zero", sw_head, 0);
        chk("R7", "tail zero", tail_idx, 0);
        chk("R7", "gen zero", gen, 0);
        chk("R7", "added ignores flush-cycle submit", added_cnt, m_added);
        chk("R7", "removed resync", removed_cnt, m_added);
        chk("R7", "no cpl on flush clock", cpl_valid, 0);
        chk("R7", "no progress on flush clock", progress, 0);
        cyc();
        chk("R7", "abort 1 valid", cpl_valid, 1);
        chk("R7", "abort 1 status", cpl_aborted, 1);
        chk("R7", "abort 1 tag", cpl_tag, 1);
        chk("R10", "head frozen in drain", sw_head, 0);
        cyc();
        chk("R7", "abort 2 valid", cpl_valid, 1);
        chk("R7", "abort 2 status", cpl_aborted, 1);
        chk("R7", "abort 2 tag", cpl_tag, 2);
        chk("R10", "head frozen in drain", sw_head, 0);
        cyc();
        chk("R7", "flush-cycle submit not aborted", cpl_valid, 0);
        chk("R10", "head frozen at drain end", sw_head, 0);
        hw_head = '0;
        m_tail = 0; m_gen = 0; m_removed = m_added;
        cyc();
        chk("R3", "removed stable", removed_cnt, m_removed);
        chk("R6", "free after flush", free_slots, DEPTH - 1);

        // Submit while the engine is stopped
        eng_running = 1'b0;
        drive_sub(5, 9, 9, 3);
        cyc();
        sub_valid = 1'b0;
        chk("R8", "added unchanged", added_cnt, m_added);
        chk("R8", "tail unchanged", tail_idx, 0);
        chk("R8", "gen unchanged", gen, 0);
        cyc();
        chk("R8", "abort valid", cpl_valid, 1);
        chk("R8", "abort status", cpl_aborted, 1);
        chk("R8", "abort tag", cpl_tag, 9);
        chk("R8", "start zero", cpl_start, 0);
        chk("R8", "end zero", cpl_end, 0);
        eng_running = 1'b1;
        cyc();
        chk("R8", "single abort", cpl_valid, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule